// File: doc/BRIEF.md
# Carry Flag Update Unit

This block is a 32-bit integer execution slice. It computes the result of one operation at a time and keeps a 32-bit fixed-point exception register. The register holds a carry flag, a status nibble at the top and a 7-bit byte-count field at the bottom. The carrying adds and subtracts, and the arithmetic right shifts, update the carry flag. Compares produce a condition nibble and never touch the carry. Two move operations either overwrite the register or copy its status bits out to a condition field and then clear them.

Operations enter on a valid/ready stream and results leave on one. An operation is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. In that same edge the exception register takes its new value and the result and condition nibble are registered. `out_valid` then holds until `out_ready` is seen. `in_ready` is high whenever the output stage is empty or is being drained in the current cycle. So a stalled consumer stalls the producer, and no operation is lost or reordered. The extended forms read the carry left by the previous accepted operation, so back-to-back chains work without gaps.

Bit positions below use little-endian numbering (bit 31 is the most significant). Opcodes on `op`: 0 add-carrying, 1 add-extended, 2 subtract-from-carrying, 3 subtract-from-extended, 4 shift-right-algebraic by `sh_amt`, 5 shift-right-algebraic by `opb[5:0]`, 6 signed compare, 7 unsigned compare, 8 full register write, 9 move status out, 10 plain add. Codes 11 to 15 are undefined.

Top module: `carry_flag_unit`

## Requirements
- R1: Opcode 0 returns `opa+opb` and opcode 1 returns `opa+opb+CA`, where CA is exception-register bit 29. Both set CA to the carry out of bit 31 and clear it otherwise.
- R2: Opcode 2 returns `~opa+opb+1` and opcode 3 returns `~opa+opb+CA`. Both set CA (bit 29) to the carry out of bit 31.
- R3: Opcodes 4 and 5 shift `opa` right arithmetically by a 6-bit amount (`sh_amt`, or `opb[5:0]`). With an amount of 32 or more every result bit equals the sign. CA (bit 29) is set only when `opa` is negative and a 1 bit was shifted out, and is cleared otherwise.
- R4: Opcodes 6 (signed) and 7 (unsigned) return result 0 and a condition nibble {LT, GT, EQ, copy of register bit 31} in bits 3 to 0, and leave CA (bit 29) unchanged.
- R5: Opcode 10 returns `opa+opb` and leaves CA unchanged. Undefined opcodes 11 to 15 return 0 and leave the whole register unchanged.
- R6: Opcode 8 loads the register from `opa` masked with 0xE000007F, so reserved bits 28 to 7 always read 0. The result is 0.
- R7: The byte-count field (bits 6 to 0) keeps its value on every accepted operation except opcode 8.
- R8: Opcode 9 outputs the old register bits 31 to 28 on the condition nibble and clears those bits, which clears CA. The result is 0.
- R9: After reset the register reads 0, `out_valid` is 0 and `in_ready` is 1.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, the result, the nibble and the register hold their values and no operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| op | input | 4 | Opcode |
| opa | input | 32 | First operand / register write data |
| opb | input | 32 | Second operand / register shift amount |
| sh_amt | input | 6 | Immediate shift amount |
| out_valid | output | 1 | Result registers hold an undelivered result |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 32 | Operation result |
| cond_nib | output | 4 | Compare or moved-out status nibble |
| xr | output | 32 | Exception register contents |

## Verification
Every result of this block appears one cycle after it is presented. The edge that accepts an operation also writes the exception register, the result, the condition nibble and `out_valid`, so all four change together. The bench drives each operation at a falling edge and reads every output at the following falling edge, half a period after the accepting edge. In the stall scenario the bench holds an offer for several cycles with `out_ready` low and checks at each falling edge that nothing moved. It then releases the stall and expects the held operation exactly one cycle later.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  localparam int XR_W     = 32;
  localparam int CA_POS   = 29;
  localparam int STAT_HI  = 31;
  localparam int STAT_LO  = 28;
  localparam int BC_W     = 7;
  localparam logic [XR_W-1:0] XR_WMASK = 32'hE000_007F;

  typedef enum logic [3:0] {
    OP_ADDC  = 4'd0,
    OP_ADDE  = 4'd1,
    OP_SUBFC = 4'd2,
    OP_SUBFE = 4'd3,
    OP_SRAI  = 4'd4,
    OP_SRAR  = 4'd5,
    OP_CMPS  = 4'd6,
    OP_CMPU  = 4'd7,
    OP_WRXR  = 4'd8,
    OP_MVST  = 4'd9,
    OP_ADD   = 4'd10
  } cfu_op_e;

  function automatic logic op_is_arith(input logic [3:0] o);
    return o inside {OP_ADDC, OP_ADDE, OP_SUBFC, OP_SUBFE};
  endfunction

  function automatic logic op_is_shift(input logic [3:0] o);
    return o inside {OP_SRAI, OP_SRAR};
  endfunction
endpackage

// File: rtl/cfu_adder.sv
module cfu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         inv_a,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] total;
  logic [W-1:0] a_eff;

  always_comb begin
    a_eff = inv_a ? ~a : a;
    total = {1'b0, a_eff} + {1'b0, b} + {{W{1'b0}}, cin};
    sum   = total[W-1:0];
    cout  = total[W];
  end
endmodule

// File: rtl/cfu_shifter.sv
module cfu_shifter #(
  parameter int W    = 32,
  parameter int SH_W = 6
) (
  input  logic [W-1:0]    a,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    res,
  output logic            ca
);
  localparam int LW = $clog2(W);

  logic            wide;
  logic [LW-1:0]   amt_s;
  logic [W-1:0]    lost_mask;

  always_comb begin
    wide      = (int'(amt) >= W);
    amt_s     = amt[LW-1:0];
    lost_mask = ~({W{1'b1}} << amt_s);
    if (wide) begin
      res = {W{a[W-1]}};
      ca  = a[W-1];
    end else begin
      res = W'($signed(a) >>> amt_s);
      ca  = a[W-1] & (|(a & lost_mask));
    end
  end
endmodule

// File: rtl/cfu_compare.sv
module cfu_compare #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         signed_cmp,
  output logic         lt,
  output logic         gt,
  output logic         eq
);
  always_comb begin
    eq = (a == b);
    if (signed_cmp) begin
      lt = ($signed(a) < $signed(b));
      gt = ($signed(a) > $signed(b));
    end else begin
      lt = (a < b);
      gt = (a > b);
    end
  end
endmodule

// File: rtl/cfu_xreg.sv
module cfu_xreg
  import cfu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic [3:0]      op,
  input  logic [XR_W-1:0] wr_data,
  input  logic            ca_new,
  output logic [XR_W-1:0] xr_q
);
  logic [XR_W-1:0] xr_d;

  always_comb begin
    xr_d = xr_q;
    if (op_is_arith(op) || op_is_shift(op)) begin
      xr_d[CA_POS] = ca_new;
    end else if (op == OP_WRXR) begin
      xr_d = wr_data & XR_WMASK;
    end else if (op == OP_MVST) begin
      xr_d[STAT_HI:STAT_LO] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   xr_q <= '0;
    else if (upd) xr_q <= xr_d;
  end

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xr_q[STAT_LO-1:BC_W] == '0);

  assert_bytecount_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd && op == OP_WRXR) |=> $stable(xr_q[BC_W-1:0]));

  assert_cmp_keeps_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && (op == OP_CMPS || op == OP_CMPU)) |=> $stable(xr_q[CA_POS]));

  assert_other_keeps_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && (op == OP_ADD || op > OP_ADD)) |=> $stable(xr_q[CA_POS]));

  assert_status_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op == OP_MVST) |=> xr_q[STAT_HI:STAT_LO] == '0);
endmodule

// File: rtl/carry_flag_unit.sv
module carry_flag_unit
  import cfu_pkg::*;
#(
  parameter int SH_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        op,
  input  logic [XR_W-1:0]   opa,
  input  logic [XR_W-1:0]   opb,
  input  logic [SH_W-1:0]   sh_amt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XR_W-1:0]   result,
  output logic [3:0]        cond_nib,
  output logic [XR_W-1:0]   xr
);
  localparam int W = XR_W;

  logic            fire;
  logic            ca_cur;
  logic            add_inv, add_cin;
  logic [W-1:0]    add_sum;
  logic            add_cout;
  logic [SH_W-1:0] sh_sel;
  logic [W-1:0]    sh_res;
  logic            sh_ca;
  logic            c_lt, c_gt, c_eq;
  logic            ca_new;
  logic [W-1:0]    res_d;
  logic [3:0]      nib_d;
  logic [W-1:0]    res_q;
  logic [3:0]      nib_q;
  logic            vld_q;

  assign in_ready = !vld_q || out_ready;
  assign fire     = in_valid && in_ready;
  assign ca_cur   = xr[CA_POS];

  always_comb begin
    add_inv = (op == OP_SUBFC) || (op == OP_SUBFE);
    unique case (op)
      OP_SUBFC:         add_cin = 1'b1;
      OP_ADDE, OP_SUBFE: add_cin = ca_cur;
      default:          add_cin = 1'b0;
    endcase
    sh_sel = (op == OP_SRAR) ? opb[SH_W-1:0] : sh_amt;
  end

  cfu_adder #(.W(W)) u_add (
    .a(opa), .b(opb), .inv_a(add_inv), .cin(add_cin),
    .sum(add_sum), .cout(add_cout)
  );

  cfu_shifter #(.W(W), .SH_W(SH_W)) u_sh (
    .a(opa), .amt(sh_sel), .res(sh_res), .ca(sh_ca)
  );

  cfu_compare #(.W(W)) u_cmp (
    .a(opa), .b(opb), .signed_cmp(op == OP_CMPS),
    .lt(c_lt), .gt(c_gt), .eq(c_eq)
  );

  always_comb begin
    res_d  = '0;
    nib_d  = '0;
    ca_new = ca_cur;
    if (op_is_arith(op)) begin
      res_d  = add_sum;
      ca_new = add_cout;
    end else if (op_is_shift(op)) begin
      res_d  = sh_res;
      ca_new = sh_ca;
    end else if (op == OP_CMPS || op == OP_CMPU) begin
      nib_d  = {c_lt, c_gt, c_eq, xr[STAT_HI]};
    end else if (op == OP_MVST) begin
      nib_d  = xr[STAT_HI:STAT_LO];
    end else if (op == OP_ADD) begin
      res_d  = add_sum;
    end
  end

  cfu_xreg u_xr (
    .clk(clk), .rst_n(rst_n), .upd(fire), .op(op),
    .wr_data(opa), .ca_new(ca_new), .xr_q(xr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      nib_q <= '0;
      vld_q <= 1'b0;
    end else if (fire) begin
      res_q <= res_d;
      nib_q <= nib_d;
      vld_q <= 1'b1;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign result    = res_q;
  assign cond_nib  = nib_q;
  assign out_valid = vld_q;

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(cond_nib)
                                   && $stable(xr)));

  assert_positive_shift_no_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_is_shift(op) && !opa[W-1]) |=> !xr[CA_POS]);

  assert_move_nibble_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_MVST) |=> cond_nib == $past(xr[STAT_HI:STAT_LO]));

  assert_addc_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_ADDC && opa[W-1] && opb[W-1]) |=> xr[CA_POS]);
endmodule

// File: tb/test_carry_flag_unit.sv
`timescale 1ns/1ps
module test_carry_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  op = '0;
  logic [31:0] opa = '0, opb = '0;
  logic [5:0]  sh_amt = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] result;
  logic [3:0]  cond_nib;
  logic [31:0] xr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  carry_flag_unit i_carry_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .opa(opa), .opb(opb), .sh_amt(sh_amt),
    .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .cond_nib(cond_nib), .xr(xr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, accepted at the next rising edge, sampled at the following falling edge
  task automatic run(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                     input logic [5:0] s);
    @(negedge clk);
    op = o; opa = a; opb = b; sh_amt = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 xr", xr, 32'h0);
    chk("R9 out_valid", {31'b0, out_valid}, 32'h0);
    chk("R9 in_ready", {31'b0, in_ready}, 32'h1);
  endtask

  task automatic t_addc;
    run(4'd8, 32'h0, 0, 0);
    run(4'd0, 32'hFFFF_FFFF, 32'h1, 0);
    chk("R1 addc wrap result", result, 32'h0);
    chk("R1 addc wrap carry", {31'b0, xr[29]}, 32'h1);
    run(4'd0, 32'h1, 32'h2, 0);
    chk("R1 addc result", result, 32'h3);
    chk("R1 addc no carry", {31'b0, xr[29]}, 32'h0);
  endtask

  task automatic t_adde;
    run(4'd0, 32'hFFFF_FFFF, 32'h1, 0);
    run(4'd1, 32'h5, 32'h6, 0);
    chk("R1 adde uses CA", result, 32'hC);
    chk("R1 adde carry clear", {31'b0, xr[29]}, 32'h0);
    run(4'd1, 32'hFFFF_FFFF, 32'h0, 0);
    chk("R1 adde CA=0 result", result, 32'hFFFF_FFFF);
    run(4'd0, 32'hFFFF_FFFF, 32'h1, 0);
    run(4'd1, 32'hFFFF_FFFF, 32'h0, 0);
    chk("R1 adde chain result", result, 32'h0);
    chk("R1 adde chain carry", {31'b0, xr[29]}, 32'h1);
  endtask

  task automatic t_subf;
    run(4'd2, 32'h5, 32'h3, 0);
    chk("R2 subfc borrow result", result, 32'hFFFF_FFFE);
    chk("R2 subfc borrow carry", {31'b0, xr[29]}, 32'h0);
    run(4'd3, 32'h3, 32'h5, 0);
    chk("R2 subfe CA=0 result", result, 32'h1);
    chk("R2 subfe CA=0 carry", {31'b0, xr[29]}, 32'h1);
    run(4'd3, 32'h3, 32'h5, 0);
    chk("R2 subfe CA=1 result", result, 32'h2);
    run(4'd2, 32'h3, 32'h5, 0);
    chk("R2 subfc result", result, 32'h2);
    chk("R2 subfc carry", {31'b0, xr[29]}, 32'h1);
  endtask

  task automatic t_shift;
    run(4'd4, 32'h8000_0001, 0, 6'd1);
    chk("R3 srai neg lost one", result, 32'hC000_0000);
    chk("R3 srai carry set", {31'b0, xr[29]}, 32'h1);
    run(4'd4, 32'h8000_0000, 0, 6'd4);
    chk("R3 srai neg lost zeros", result, 32'hF800_0000);
    chk("R3 srai carry clear", {31'b0, xr[29]}, 32'h0);
    run(4'd0, 32'hFFFF_FFFF, 32'h1, 0);
    run(4'd4, 32'h7FFF_FFFF, 0, 6'd4);
    chk("R3 srai positive", result, 32'h07FF_FFFF);
    chk("R3 srai positive carry", {31'b0, xr[29]}, 32'h0);
    run(4'd5, 32'h8000_0000, 32'd40, 6'd0);
    chk("R3 srar wide neg", result, 32'hFFFF_FFFF);
    chk("R3 srar wide neg carry", {31'b0, xr[29]}, 32'h1);
    run(4'd5, 32'h1234_5678, 32'd33, 6'd0);
    chk("R3 srar wide pos", result, 32'h0);
    chk("R3 srar wide pos carry", {31'b0, xr[29]}, 32'h0);
    run(4'd5, 32'hFFFF_FFFF, 32'd0, 6'd9);
    chk("R3 srar amount zero", result, 32'hFFFF_FFFF);
    chk("R3 srar amount zero carry", {31'b0, xr[29]}, 32'h0);
  endtask

  task automatic t_compare;
    run(4'd0, 32'hFFFF_FFFF, 32'h1, 0);
    run(4'd6, 32'hFFFF_FFFF, 32'h1, 0);
    chk("R4 signed lt", {28'b0, cond_nib}, 32'h8);
    chk("R4 cmp result", result, 32'h0);
    chk("R4 cmp keeps carry", {31'b0, xr[29]}, 32'h1);
    run(4'd7, 32'hFFFF_FFFF, 32'h1, 0);
    chk("R4 unsigned gt", {28'b0, cond_nib}, 32'h4);
    run(4'd8, 32'h8000_0000, 0, 0);
    run(4'd6, 32'h77, 32'h77, 0);
    chk("R4 eq with top bit copy", {28'b0, cond_nib}, 32'h3);
    chk("R4 cmp keeps carry clear", {31'b0, xr[29]}, 32'h0);
  endtask

  task automatic t_other;
    run(4'd8, 32'h0, 0, 0);
    run(4'd10, 32'hFFFF_FFFF, 32'h1, 0);
    chk("R5 add result", result, 32'h0);
    chk("R5 add no carry", {31'b0, xr[29]}, 32'h0);
    run(4'd0, 32'hFFFF_FFFF, 32'h1, 0);
    run(4'd10, 32'h2, 32'h3, 0);
    chk("R5 add keeps carry", {31'b0, xr[29]}, 32'h1);
    run(4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'h3F);
    chk("R5 undefined result", result, 32'h0);
    chk("R5 undefined keeps xr", xr, 32'h2000_0000);
  endtask

  task automatic t_layout;
    run(4'd8, 32'hFFFF_FFFF, 0, 0);
    chk("R6 write mask", xr, 32'hE000_007F);
    chk("R6 write result", result, 32'h0);
    run(4'd8, 32'h0000_005A, 0, 0);
    chk("R6 byte count write", xr, 32'h0000_005A);
  endtask

  task automatic t_bytecount;
    run(4'd0, 32'hFFFF_FFFF, 32'h1, 0);
    run(4'd5, 32'h8000_0001, 32'd3, 0);
    run(4'd6, 32'h1, 32'h2, 0);
    run(4'd10, 32'h1, 32'h2, 0);
    run(4'd9, 0, 0, 0);
    chk("R7 byte count kept", {25'b0, xr[6:0]}, 32'h5A);
  endtask

  task automatic t_move;
    run(4'd8, 32'hA000_0011, 0, 0);
    run(4'd9, 0, 0, 0);
    chk("R8 nibble out", {28'b0, cond_nib}, 32'hA);
    chk("R8 status cleared", xr, 32'h0000_0011);
    chk("R8 move result", result, 32'h0);
  endtask

  task automatic t_stall;
    run(4'd8, 32'h0, 0, 0);
    @(negedge clk);
    chk("R10 idle drop valid", {31'b0, out_valid}, 32'h0);
    out_ready = 1'b0;
    run(4'd0, 32'h1, 32'h2, 0);
    chk("R10 first result", result, 32'h3);
    chk("R10 ready low", {31'b0, in_ready}, 32'h0);
    op = 4'd0; opa = 32'hFFFF_FFFF; opb = 32'h1; in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 held result", result, 32'h3);
      chk("R10 held carry", {31'b0, xr[29]}, 32'h0);
      chk("R10 held valid", {31'b0, out_valid}, 32'h1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 released result", result, 32'h0);
    chk("R10 released carry", {31'b0, xr[29]}, 32'h1);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addc();
    t_adde();
    t_subf();
    t_shift();
    t_compare();
    t_other();
    t_layout();
    t_bytecount();
    t_move();
    t_stall();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule